// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block steers a small processor core between normal execution, a light sleep and a deep sleep. In light sleep the CPU clock is gated while the oscillator and the peripheral clock keep running. In deep sleep the oscillator is turned off, so every clock in the core stops. Entry into either sleep state produces a one-cycle request to clear the core's interrupt mask, so that a waking interrupt can be taken at once.

A wake event comes from a reset request or from an interrupt. Any interrupt line wakes the core from light sleep. Only lines enabled in a wake mask wake it from deep sleep. Every wake passes through a stabilisation phase. In that phase the oscillator and the CPU clock are on and the peripheral clock stays gated. The phase lasts 256 or 4096 cycles, selected by a static input.

When the phase ends, a single-cycle completion pulse marks the return to normal execution. At the same time a select output tells the core either to fetch the reset vector or to service the interrupts reported on a held vector. A reset request restarts the stabilisation phase whenever it arrives.

Top module: `lpm_seq_top`

## Requirements
- R1: After the block reset, the oscillator, CPU clock and peripheral clock enables are all 1. The completion pulse, the mask-clear request, the reset-vector select and the held interrupt vector are all 0.
- R2: A light-sleep strobe in normal execution moves the block to light sleep at the next clock edge. There the CPU clock enable is 0, the oscillator and peripheral clock enables are 1, and the mask-clear output is 1 for exactly that first sleep cycle.
- R3: A deep-sleep strobe in normal execution, with both the auto-wake enable and the active-halt enable at 0, moves the block to deep sleep at the next edge. There all three enables are 0 and mask-clear pulses for one cycle. When both strobes arrive together, deep sleep wins.
- R4: A deep-sleep strobe with the auto-wake enable or the active-halt enable at 1 has no effect: the block stays in normal execution.
- R5: Any asserted interrupt line ends light sleep at the next edge. Deep sleep ends only on a line i that is asserted while bit i of the wake mask is 1; unmasked lines are ignored. An interrupt already pending in the first sleep cycle wakes the block at the following edge.
- R6: During stabilisation the oscillator and CPU clock enables are 1 and the peripheral clock enable is 0. Stabilisation lasts exactly 256 cycles when the delay select is 0 and 4096 cycles when it is 1. Normal execution then resumes with all enables at 1.
- R7: The completion pulse is 1 for exactly the first cycle back in normal execution. The reset-vector select reads 1 after a reset-caused wake and 0 after an interrupt-caused wake. The held interrupt vector shows the lines that caused the wake.
- R8: A reset request wins over an interrupt in the same cycle. A reset request in any state, including normal execution and stabilisation, starts a full-length stabilisation with the reset cause and an empty interrupt vector.
- R9: Interrupt lines asserted during an interrupt-caused stabilisation are ORed into the held interrupt vector, so they are reported with the completion pulse.
- R10: Sleep strobes that arrive outside normal execution have no effect on the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| wfi_i | input | 1 | Light-sleep strobe |
| halt_i | input | 1 | Deep-sleep strobe |
| auto_wake_en_i | input | 1 | Auto-wake enable; blocks deep sleep when 1 |
| act_halt_en_i | input | 1 | Active-halt enable; blocks deep sleep when 1 |
| long_dly_i | input | 1 | Stabilisation length select: 0 gives 256 cycles, 1 gives 4096 |
| rst_req_i | input | 1 | Reset wake request |
| irq_i | input | N_IRQ | Interrupt request lines |
| wake_mask_i | input | N_IRQ | Per-line deep-sleep wake enable |
| osc_en_o | output | 1 | Oscillator enable |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| imask_clr_o | output | 1 | One-cycle request to clear the interrupt mask bit |
| done_o | output | 1 | One-cycle pulse on return to normal execution |
| rst_vec_sel_o | output | 1 | 1: fetch the reset vector; 0: service the interrupts |
| wake_irq_o | output | N_IRQ | Interrupt lines that caused or joined the wake |

## Verification
The wake paths are driven with single-line pulses, with lines held high across sleep entry, and with unmasked lines during deep sleep. These patterns separate the mask handling of light sleep from that of deep sleep, and show that an already pending interrupt wakes the block at once. Reset requests are applied alone, together with an interrupt, in normal execution and in the middle of stabilisation. Cycle counts from the restart point then show whether the count truly begins again and whether the cause select turns to reset. Strobes are also issued during sleep and during stabilisation, deep sleep is attempted with each blocking enable set, and both delay lengths are measured to the exact cycle.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_WAIT = 2'd1,
        ST_HALT = 2'd2,
        ST_STAB = 2'd3
    } lpm_state_e;

    localparam logic CAUSE_IRQ = 1'b0;
    localparam logic CAUSE_RST = 1'b1;
endpackage

// File: rtl/lpm_wake_sel.sv
module lpm_wake_sel
    import lpm_pkg::*;
#(
    parameter int N_IRQ = 8
) (
    input  lpm_state_e       state_i,
    input  logic [N_IRQ-1:0] irq_i,
    input  logic [N_IRQ-1:0] mask_i,
    output logic [N_IRQ-1:0] vec_o,
    output logic             any_o
);
    logic in_wait;
    logic in_halt;
    logic in_stab;

    assign in_wait = (state_i == ST_WAIT);
    assign in_halt = (state_i == ST_HALT);
    assign in_stab = (state_i == ST_STAB);

    // per-line qualification: any line in light sleep or stabilisation,
    // only mask-enabled lines in deep sleep
    for (genvar g = 0; g < N_IRQ; g++) begin : g_line
        assign vec_o[g] = irq_i[g] & (in_wait | in_stab | (in_halt & mask_i[g]));
    end

    assign any_o = (|vec_o) & (in_wait | in_halt);
endmodule

// File: rtl/lpm_stab_timer.sv
module lpm_stab_timer #(
    parameter int unsigned SHORT_CYC = 256,
    parameter int unsigned LONG_CYC  = 4096
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic run_i,
    input  logic long_i,
    output logic expire_o
);
    localparam int unsigned MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int          CW      = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] last_cnt;

    assign last_cnt = long_i ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = '0;
        end else if (run_i && (cnt_q < last_cnt)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expire_o = run_i && (cnt_q >= last_cnt);

    // R8: a restart always begins the count from zero
    a_r8_restart_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (cnt_q == '0));

    // R6: while running and not restarted, the count advances by one each cycle
    a_r6_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !start_i && !expire_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int N_IRQ = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wfi_i,
    input  logic             halt_i,
    input  logic             auto_wake_en_i,
    input  logic             act_halt_en_i,
    input  logic             rst_req_i,
    input  logic             wake_any_i,
    input  logic [N_IRQ-1:0] wake_vec_i,
    input  logic             expire_i,
    output lpm_state_e       state_o,
    output logic             tmr_start_o,
    output logic             cause_o,
    output logic [N_IRQ-1:0] pend_o,
    output logic             mclr_o,
    output logic             done_o
);
    typedef struct packed {
        lpm_state_e       st;
        logic             cause;
        logic [N_IRQ-1:0] pend;
        logic             mclr;
        logic             done;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  start_d;
    logic  halt_ok;

    assign halt_ok = !auto_wake_en_i && !act_halt_en_i;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.mclr = 1'b0;
        ctl_d.done = 1'b0;
        start_d    = 1'b0;
        unique case (ctl_q.st)
            ST_RUN: begin
                if (rst_req_i) begin
                    ctl_d.st    = ST_STAB;
                    ctl_d.cause = CAUSE_RST;
                    ctl_d.pend  = '0;
                    start_d     = 1'b1;
                end else if (halt_i) begin
                    if (halt_ok) begin
                        ctl_d.st   = ST_HALT;
                        ctl_d.mclr = 1'b1;
                    end
                end else if (wfi_i) begin
                    ctl_d.st   = ST_WAIT;
                    ctl_d.mclr = 1'b1;
                end
            end
            ST_WAIT, ST_HALT: begin
                if (rst_req_i) begin
                    ctl_d.st    = ST_STAB;
                    ctl_d.cause = CAUSE_RST;
                    ctl_d.pend  = '0;
                    start_d     = 1'b1;
                end else if (wake_any_i) begin
                    ctl_d.st    = ST_STAB;
                    ctl_d.cause = CAUSE_IRQ;
                    ctl_d.pend  = wake_vec_i;
                    start_d     = 1'b1;
                end
            end
            ST_STAB: begin
                if (rst_req_i) begin
                    ctl_d.cause = CAUSE_RST;
                    ctl_d.pend  = '0;
                    start_d     = 1'b1;
                end else begin
                    if (ctl_q.cause == CAUSE_IRQ) begin
                        ctl_d.pend = ctl_q.pend | wake_vec_i;
                    end
                    if (expire_i) begin
                        ctl_d.st   = ST_RUN;
                        ctl_d.done = 1'b1;
                    end
                end
            end
            default: ctl_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '{st: ST_RUN, cause: CAUSE_IRQ, pend: '0, mclr: 1'b0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign state_o     = ctl_q.st;
    assign tmr_start_o = start_d;
    assign cause_o     = ctl_q.cause;
    assign pend_o      = ctl_q.pend;
    assign mclr_o      = ctl_q.mclr;
    assign done_o      = ctl_q.done;

    // R10: a sleep state is held unless a reset request or a qualified wake arrives
    a_r10_hold_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((ctl_q.st == ST_WAIT || ctl_q.st == ST_HALT) && !rst_req_i && !wake_any_i)
        |=> (ctl_q.st == $past(ctl_q.st)));

    // R4: a blocked deep-sleep strobe leaves the block in normal execution
    a_r4_halt_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.st == ST_RUN && halt_i && !halt_ok && !rst_req_i) |=> (ctl_q.st == ST_RUN));

    // R8: a reset request always leads to stabilisation with the reset cause
    a_r8_rst_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_i |=> (ctl_q.st == ST_STAB && ctl_q.cause == CAUSE_RST && ctl_q.pend == '0));
endmodule

// File: rtl/lpm_seq_top.sv
module lpm_seq_top
    import lpm_pkg::*;
#(
    parameter int          N_IRQ     = 8,
    parameter int unsigned SHORT_CYC = 256,
    parameter int unsigned LONG_CYC  = 4096
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wfi_i,
    input  logic             halt_i,
    input  logic             auto_wake_en_i,
    input  logic             act_halt_en_i,
    input  logic             long_dly_i,
    input  logic             rst_req_i,
    input  logic [N_IRQ-1:0] irq_i,
    input  logic [N_IRQ-1:0] wake_mask_i,
    output logic             osc_en_o,
    output logic             cpu_clk_en_o,
    output logic             periph_clk_en_o,
    output logic             imask_clr_o,
    output logic             done_o,
    output logic             rst_vec_sel_o,
    output logic [N_IRQ-1:0] wake_irq_o
);
    lpm_state_e       state;
    logic [N_IRQ-1:0] wake_vec;
    logic             wake_any;
    logic             tmr_start;
    logic             tmr_expire;

    lpm_wake_sel #(.N_IRQ(N_IRQ)) u_wake (
        .state_i (state),
        .irq_i   (irq_i),
        .mask_i  (wake_mask_i),
        .vec_o   (wake_vec),
        .any_o   (wake_any)
    );

    lpm_stab_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (tmr_start),
        .run_i    (state == ST_STAB),
        .long_i   (long_dly_i),
        .expire_o (tmr_expire)
    );

    lpm_ctrl #(.N_IRQ(N_IRQ)) u_ctrl (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .wfi_i          (wfi_i),
        .halt_i         (halt_i),
        .auto_wake_en_i (auto_wake_en_i),
        .act_halt_en_i  (act_halt_en_i),
        .rst_req_i      (rst_req_i),
        .wake_any_i     (wake_any),
        .wake_vec_i     (wake_vec),
        .expire_i       (tmr_expire),
        .state_o        (state),
        .tmr_start_o    (tmr_start),
        .cause_o        (rst_vec_sel_o),
        .pend_o         (wake_irq_o),
        .mclr_o         (imask_clr_o),
        .done_o         (done_o)
    );

    assign osc_en_o        = (state != ST_HALT);
    assign cpu_clk_en_o    = (state == ST_RUN) || (state == ST_STAB);
    assign periph_clk_en_o = (state == ST_RUN) || (state == ST_WAIT);

    // R2: a light-sleep strobe alone in normal execution gates only the CPU clock
    a_r2_wait_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (osc_en_o && cpu_clk_en_o && periph_clk_en_o && wfi_i && !halt_i && !rst_req_i)
        |=> (!cpu_clk_en_o && osc_en_o && periph_clk_en_o && imask_clr_o));

    // R7: the completion pulse never lasts two cycles
    a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R6: the peripheral clock comes back only together with the completion pulse
    a_r6_periph_resume: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(periph_clk_en_o) |-> done_o);

    // R3: the mask-clear request appears only on entry to a sleep state
    a_r3_mclr_on_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        imask_clr_o |-> (!cpu_clk_en_o && !done_o));
endmodule

// File: tb/lpm_seq_top_tb_top.sv
module lpm_seq_top_tb_top;
    localparam int NI = 8;

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic          wfi = 1'b0, halt = 1'b0, awu = 1'b0, act = 1'b0, long_dly = 1'b0, rst_req = 1'b0;
    logic [NI-1:0] irq = '0, mask = '0;
    logic          osc, cpu, per, mclr, done, sel;
    logic [NI-1:0] wirq;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  chk_on = 1'b0;

    // reference model: 0 normal, 1 light sleep, 2 deep sleep, 3 stabilisation
    int            m_st = 0;
    int            m_left = 0;
    bit            m_cause = 1'b0;
    logic [NI-1:0] m_pend = '0;
    bit            m_mclr = 1'b0;
    bit            m_done = 1'b0;

    always #4 clk = ~clk;

    lpm_seq_top #(.N_IRQ(NI)) dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .wfi_i(wfi), .halt_i(halt),
        .auto_wake_en_i(awu), .act_halt_en_i(act), .long_dly_i(long_dly),
        .rst_req_i(rst_req), .irq_i(irq), .wake_mask_i(mask),
        .osc_en_o(osc), .cpu_clk_en_o(cpu), .periph_clk_en_o(per),
        .imask_clr_o(mclr), .done_o(done), .rst_vec_sel_o(sel), .wake_irq_o(wirq)
    );

    function automatic int dly_len();
        return long_dly ? 4096 : 256;
    endfunction

    always @(posedge clk) begin
        if (!rst_ni) begin
            m_st = 0; m_left = 0; m_cause = 1'b0; m_pend = '0; m_mclr = 1'b0; m_done = 1'b0;
        end else begin
            m_mclr = 1'b0;
            m_done = 1'b0;
            if (rst_req) begin
                m_st = 3; m_left = dly_len(); m_cause = 1'b1; m_pend = '0;
            end else if (m_st == 0) begin
                if (halt) begin
                    if (!awu && !act) begin m_st = 2; m_mclr = 1'b1; end
                end else if (wfi) begin
                    m_st = 1; m_mclr = 1'b1;
                end
            end else if (m_st == 1 && irq != 0) begin
                m_st = 3; m_left = dly_len(); m_cause = 1'b0; m_pend = irq;
            end else if (m_st == 2 && (irq & mask) != 0) begin
                m_st = 3; m_left = dly_len(); m_cause = 1'b0; m_pend = irq & mask;
            end else if (m_st == 3) begin
                if (!m_cause) m_pend = m_pend | irq;
                if (m_left == 1) begin m_st = 0; m_done = 1'b1; end
                else m_left = m_left - 1;
            end
        end
    end

    task automatic cmp(string tag, int act_v, int exp_v, string what);
        n_vec++;
        if (act_v != exp_v) begin
            n_bad++;
            $display("FAIL %s %s at %0t: actual %0h expected %0h", tag, what, $time, act_v, exp_v);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            string tg;
            tg = (m_st == 0) ? "R1" : (m_st == 1) ? "R2" : (m_st == 2) ? "R3" : "R6";
            cmp(tg, int'(osc), int'(m_st != 2), "osc_en");
            cmp(tg, int'(cpu), int'(m_st == 0 || m_st == 3), "cpu_clk_en");
            cmp(tg, int'(per), int'(m_st == 0 || m_st == 1), "periph_clk_en");
            cmp("R2", int'(mclr), int'(m_mclr), "imask_clr");
            cmp("R7", int'(done), int'(m_done), "done");
            cmp("R7", int'(sel), int'(m_cause), "rst_vec_sel");
            cmp("R9", int'(wirq), int'(m_pend), "wake_irq");
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wait_done(output int k);
        k = 0;
        while (!done && k < 6000) begin
            step();
            k++;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL R6 watchdog expired: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int k;
        mask = 8'h01;
        @(posedge clk);
        chk_on = 1'b1;
        #2;
        steps(2);
        rst_ni = 1'b1;
        step();
        cmp("R1", int'({osc, cpu, per}), 7, "enables after reset");

        // R2 / R5 / R6 / R7: light sleep, single-line wake, short delay
        wfi = 1'b1; step(); wfi = 1'b0;
        cmp("R2", int'({osc, cpu, per}), 5, "light-sleep enables");
        steps(3);
        irq = 8'h08; step(); irq = '0;
        wait_done(k);
        cmp("R6", k, 256, "short delay length");
        cmp("R7", int'(sel), 0, "select after interrupt wake");
        cmp("R7", int'(wirq), 8'h08, "waking line");

        // R3 / R5 / R9: deep sleep, unmasked line ignored, late line joins
        halt = 1'b1; step(); halt = 1'b0;
        cmp("R3", int'({osc, cpu, per}), 0, "deep-sleep enables");
        irq = 8'h10; steps(5);
        cmp("R5", int'(osc), 0, "unmasked line ignored in deep sleep");
        irq = 8'h01; step(); irq = '0;
        cmp("R6", int'({osc, cpu, per}), 6, "stabilisation enables");
        steps(20);
        irq = 8'h40; step(); irq = '0;
        wait_done(k);
        cmp("R9", int'(wirq), 8'h41, "accumulated lines");

        // R4: deep sleep blocked by either enable
        awu = 1'b1; halt = 1'b1; step(); halt = 1'b0;
        cmp("R4", int'(cpu), 1, "halt with auto-wake enable");
        awu = 1'b0; act = 1'b1; halt = 1'b1; step(); halt = 1'b0; act = 1'b0;
        cmp("R4", int'(cpu), 1, "halt with active-halt enable");

        // R10: strobes outside normal execution
        wfi = 1'b1; step(); wfi = 1'b0;
        halt = 1'b1; step(); halt = 1'b0;
        cmp("R10", int'({osc, cpu}), 2, "halt strobe in light sleep");
        irq = 8'h01; step(); irq = '0;
        wfi = 1'b1; step(); wfi = 1'b0; step();
        cmp("R10", int'(cpu), 1, "wfi strobe in stabilisation");
        wait_done(k);

        // R8: reset with interrupt, then restart in the middle of stabilisation
        halt = 1'b1; step(); halt = 1'b0;
        rst_req = 1'b1; irq = 8'h01; step(); rst_req = 1'b0; irq = '0;
        steps(100);
        rst_req = 1'b1; step(); rst_req = 1'b0;
        wait_done(k);
        cmp("R8", k, 256, "restarted delay length");
        cmp("R8", int'(sel), 1, "select after reset wake");
        cmp("R8", int'(wirq), 0, "vector after reset wake");

        // R5: interrupt pending at sleep entry wakes at once
        irq = 8'h02; wfi = 1'b1; step(); wfi = 1'b0; step();
        cmp("R5", int'({cpu, per}), 2, "pending interrupt wake");
        irq = '0;
        wait_done(k);

        // R3: both strobes together pick deep sleep
        wfi = 1'b1; halt = 1'b1; step(); wfi = 1'b0; halt = 1'b0;
        cmp("R3", int'(osc), 0, "deep sleep wins over light sleep");
        rst_req = 1'b1; step(); rst_req = 1'b0;
        wait_done(k);

        // R8: reset request in normal execution
        rst_req = 1'b1; step(); rst_req = 1'b0;
        cmp("R8", int'(per), 0, "reset request in normal execution");
        wait_done(k);

        // R6: long delay
        long_dly = 1'b1;
        wfi = 1'b1; step(); wfi = 1'b0;
        irq = 8'h80; step(); irq = '0;
        wait_done(k);
        cmp("R6", k, 4096, "long delay length");
        steps(4);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule